// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address. It reads one entry from a page table that sits in a word-addressed memory. A requester hands over a virtual address, a read/write flag and a privilege flag (user or supervisor) through a valid/ready handshake. The walker then fetches the entry that belongs to that page, at the table base plus the virtual page number. It checks the entry for presence and for permission. When the access is allowed, it returns the frame number joined to the untouched page offset. When it is not allowed, it reports a page fault or a protection fault.

The walker maintains the entry's usage bits in memory. Any permitted access marks the entry referenced, and a permitted write also marks it modified. The updated word is stored back only when one of those bits actually flips, so a repeated access to a warm page costs a single memory read. Only one walk is in flight at a time. The memory side is a plain request/response port: every read returns exactly one response, and writes are fire-and-forget.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: Each walk issues its entry read at address `pt_base + req_vaddr[31:12]`, computed modulo 2^32, with one 32-bit word per entry. If the walk writes the entry back, the write goes to that same address.
- R3: On success, `rsp_paddr` is the entry's bits [31:12] followed by `req_vaddr[11:0]`, and both fault flags are 0.
- R4: An entry whose present bit (bit 0) is 0 gives `rsp_page_fault`=1 and `rsp_paddr`=0. The entry is not written back.
- R5: An access violates protection if it is a write and the writable bit (bit 1) is 0, or if it is a user access (`req_user`=1) and the user bit (bit 2) is 0. A violating access on a present entry gives `rsp_prot_fault`=1 and `rsp_paddr`=0, and leaves the entry unchanged in memory.
- R6: A permitted access sets the referenced bit (bit 3) of the entry in memory. A permitted write also sets the modified bit (bit 4). All other entry bits keep their values.
- R7: The entry is written back only when the referenced or modified bit changes. Otherwise the walk makes exactly one memory access.
- R8: Once a request is accepted, `req_ready` stays 0 until the walk completes. Each accepted request produces exactly one `rsp_valid` pulse, one cycle long.
- R9: When an entry is not present, the page fault is reported and the protection fault is not, whatever the permission bits hold.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request and its address, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| pt_base | input | 32 | Word address of the first page-table entry |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 to write an entry, 0 to read one |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | Translation result, one-cycle pulse |
| rsp_paddr | output | 32 | Physical address, 0 on any fault |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Access forbidden by permission bits |

## Verification
The checker watches several rules on every cycle: the single-walk rule, the one-cycle result pulse, that memory requests hold steady under back-pressure, that the two fault flags never appear together, that a faulted result carries a zero address, that every memory request uses the entry address captured at acceptance, and that every stored entry is present with its referenced bit set. The values of the translated address, the exact entry bits written back, and whether a write-back happens at all depend on the table contents. Only the bench's scenarios can show these, since the bench reads its own memory model after each walk and counts the reads and writes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Bit positions of the permission and usage flags within a table entry
    localparam int PTE_PRESENT = 0;
    localparam int PTE_WRITE   = 1;
    localparam int PTE_USER    = 2;
    localparam int PTE_REF     = 3;
    localparam int PTE_DIRTY   = 4;

    typedef enum logic [2:0] {
        WALK_IDLE  = 3'd0,
        WALK_RD    = 3'd1,
        WALK_RWAIT = 3'd2,
        WALK_WB    = 3'd3,
        WALK_DONE  = 3'd4
    } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int AW    = 32
) (
    input  logic [AW-1:0]   base,
    input  logic [VA_W-1:0] vaddr,
    output logic [AW-1:0]   entry_addr
);
    localparam int VPN_W = VA_W - OFF_W;

    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn        = vaddr[VA_W-1:OFF_W];
        entry_addr = base + AW'(vpn);
    end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [WORD_W-1:0] pte,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_write,
    input  logic              is_user,
    output logic              page_fault,
    output logic              prot_fault,
    output logic              need_wb,
    output logic [WORD_W-1:0] pte_new,
    output logic [WORD_W-1:0] paddr
);
    localparam int FRAME_W = WORD_W - OFF_W;

    logic deny_write;
    logic deny_user;

    always_comb begin
        deny_write = is_write && !pte[PTE_WRITE];
        deny_user  = is_user && !pte[PTE_USER];
        page_fault = !pte[PTE_PRESENT];
        prot_fault = pte[PTE_PRESENT] && (deny_write || deny_user);

        pte_new            = pte;
        pte_new[PTE_REF]   = 1'b1;
        if (is_write) begin
            pte_new[PTE_DIRTY] = 1'b1;
        end

        need_wb = !page_fault && !prot_fault && (pte_new != pte);

        if (page_fault || prot_fault) begin
            paddr = '0;
        end else begin
            paddr = {pte[WORD_W-1:OFF_W], offset};
        end
    end

    logic [FRAME_W-1:0] unused_frame_view;
    assign unused_frame_view = pte[WORD_W-1:OFF_W];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int AW     = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [AW-1:0]     pt_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [AW-1:0]     mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_paddr,
    output logic              rsp_page_fault,
    output logic              rsp_prot_fault
);
    typedef struct packed {
        walk_state_e       st;
        logic [VA_W-1:0]   vaddr;
        logic              wr;
        logic              usr;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] pte;
        logic [WORD_W-1:0] paddr;
        logic              pf;
        logic              prot;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [AW-1:0]     new_entry_addr;
    logic              ev_pf, ev_prot, ev_wb;
    logic [WORD_W-1:0] ev_pte, ev_paddr;

    ptw_entry_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .AW(AW)) u_addr (
        .base       (pt_base),
        .vaddr      (req_vaddr),
        .entry_addr (new_entry_addr)
    );

    ptw_pte_eval #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_eval (
        .pte        (mem_rsp_rdata),
        .offset     (r_q.vaddr[OFF_W-1:0]),
        .is_write   (r_q.wr),
        .is_user    (r_q.usr),
        .page_fault (ev_pf),
        .prot_fault (ev_prot),
        .need_wb    (ev_wb),
        .pte_new    (ev_pte),
        .paddr      (ev_paddr)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WALK_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr = req_vaddr;
                    r_d.wr    = req_write;
                    r_d.usr   = req_user;
                    r_d.addr  = new_entry_addr;
                    r_d.st    = WALK_RD;
                end
            end
            WALK_RD: begin
                if (mem_req_ready) begin
                    r_d.st = WALK_RWAIT;
                end
            end
            WALK_RWAIT: begin
                if (mem_rsp_valid) begin
                    r_d.pte   = ev_pte;
                    r_d.paddr = ev_paddr;
                    r_d.pf    = ev_pf;
                    r_d.prot  = ev_prot;
                    r_d.st    = ev_wb ? WALK_WB : WALK_DONE;
                end
            end
            WALK_WB: begin
                if (mem_req_ready) begin
                    r_d.st = WALK_DONE;
                end
            end
            WALK_DONE: begin
                r_d.st = WALK_IDLE;
            end
            default: r_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WALK_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready      = (r_q.st == WALK_IDLE);
        mem_req_valid  = (r_q.st == WALK_RD) || (r_q.st == WALK_WB);
        mem_req_write  = (r_q.st == WALK_WB);
        mem_req_addr   = r_q.addr;
        mem_req_wdata  = (r_q.st == WALK_WB) ? r_q.pte : '0;
        rsp_valid      = (r_q.st == WALK_DONE);
        rsp_paddr      = rsp_valid ? r_q.paddr : '0;
        rsp_page_fault = rsp_valid && r_q.pf;
        rsp_prot_fault = rsp_valid && r_q.prot;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int AW     = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              req_write,
    input logic              req_user,
    input logic [AW-1:0]     pt_base,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [AW-1:0]     mem_req_addr,
    input logic [WORD_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic [WORD_W-1:0] mem_rsp_rdata,
    input logic              rsp_valid,
    input logic [WORD_W-1:0] rsp_paddr,
    input logic              rsp_page_fault,
    input logic              rsp_prot_fault
);
    logic [AW-1:0] want_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_addr_q <= '0;
        end else if (req_valid && req_ready) begin
            want_addr_q <= pt_base + AW'(req_vaddr[VA_W-1:OFF_W]);
        end
    end

    // R8
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));

    // R4
    fault_noaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_paddr == '0));

    // R2
    entry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr == want_addr_q));

    // R6
    wb_marks_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |->
            (mem_req_wdata[PTE_REF] && mem_req_wdata[PTE_PRESENT]));

    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .AW(AW), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] pt_base = 32'h40;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        rsp_valid, rsp_page_fault, rsp_prot_fault;
    logic [31:0] rsp_paddr;

    always #4 clk = ~clk;

    ptw_walker uut (.*);

    // Memory model with preload and counter-clear controls
    logic [31:0] mem [256];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_idx = '0;
    logic [31:0] pl_data = '0;
    logic        clr = 1'b0;
    logic        stall = 1'b0;
    logic        tick;
    int          rd_cnt, wr_cnt;
    logic [31:0] last_rd_addr, last_wr_addr;

    assign mem_req_ready = !stall || tick;

    always @(posedge clk) begin
        tick          <= !rst_n ? 1'b0 : ~tick;
        mem_rsp_valid <= 1'b0;
        if (clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end
        if (pl_en) mem[pl_idx] <= pl_data;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[7:0]] <= mem_req_wdata;
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_req_addr;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[7:0]];
                rd_cnt        <= rd_cnt + 1;
                last_rd_addr  <= mem_req_addr;
            end
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] idx, input logic [31:0] data);
        @(negedge clk);
        pl_en = 1'b1; pl_idx = idx; pl_data = data; clr = 1'b1;
        @(negedge clk);
        pl_en = 1'b0; clr = 1'b0;
    endtask

    logic        got_pf, got_prot;
    logic [31:0] got_paddr;

    task automatic walk(input logic [31:0] va, input logic wr, input logic usr);
        int n;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", {31'd0, req_ready}, 32'd0);
        n = 0;
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R8 response arrives", {31'd0, rsp_valid}, 32'd1);
        got_pf = rsp_page_fault; got_prot = rsp_prot_fault; got_paddr = rsp_paddr;
        @(negedge clk);
        chk("R8 single pulse", {31'd0, rsp_valid}, 32'd0);
        chk("R8 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    typedef struct packed {
        logic [19:0] vpn;
        logic [11:0] off;
        logic        wr;
        logic        usr;
        logic [31:0] pte;
        logic        pf;
        logic        prot;
        logic [31:0] pte_after;
        logic [1:0]  nwr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{20'h00001, 12'habc, 1'b0, 1'b1, 32'h12345007, 1'b0, 1'b0, 32'h1234500F, 2'd1},
        '{20'h00002, 12'h123, 1'b0, 1'b1, 32'h1234500F, 1'b0, 1'b0, 32'h1234500F, 2'd0},
        '{20'h00003, 12'h7ff, 1'b1, 1'b1, 32'hABCDE00F, 1'b0, 1'b0, 32'hABCDE01F, 2'd1},
        '{20'h00004, 12'h000, 1'b1, 1'b1, 32'h0000701F, 1'b0, 1'b0, 32'h0000701F, 2'd0},
        '{20'h00005, 12'h555, 1'b0, 1'b1, 32'h55555006, 1'b1, 1'b0, 32'h55555006, 2'd0},
        '{20'h00006, 12'h010, 1'b1, 1'b1, 32'h22222005, 1'b0, 1'b1, 32'h22222005, 2'd0},
        '{20'h00007, 12'h020, 1'b0, 1'b1, 32'h33333003, 1'b0, 1'b1, 32'h33333003, 2'd0},
        '{20'h00008, 12'h030, 1'b0, 1'b0, 32'h33333003, 1'b0, 1'b0, 32'h3333300B, 2'd1},
        '{20'h00009, 12'hfff, 1'b1, 1'b1, 32'h00000004, 1'b1, 1'b0, 32'h00000004, 2'd0},
        '{20'h0000A, 12'h001, 1'b1, 1'b0, 32'h44444003, 1'b0, 1'b0, 32'h4444401B, 2'd1}
    };

    task automatic run_vec(input vec_t v, input logic [31:0] base);
        logic [31:0] ea, exp_pa;
        ea = base + {12'd0, v.vpn};
        pt_base = base;
        poke(ea[7:0], v.pte);
        walk({v.vpn, v.off}, v.wr, v.usr);
        exp_pa = (v.pf || v.prot) ? 32'd0 : {v.pte[31:12], v.off};
        chk("R4 page fault flag", {31'd0, got_pf}, {31'd0, v.pf});
        chk("R5 R9 protection flag", {31'd0, got_prot}, {31'd0, v.prot});
        chk("R3 physical address", got_paddr, exp_pa);
        chk("R2 entry read address", last_rd_addr, ea);
        chk("R7 read count", rd_cnt, 32'd1);
        chk("R7 write-back count", wr_cnt, {30'd0, v.nwr});
        chk("R6 entry in memory", mem[ea[7:0]], v.pte_after);
        if (v.nwr != 0) chk("R2 write-back address", last_wr_addr, ea);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no mem req in reset", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 no rsp in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 idle after reset", {31'd0, mem_req_valid | rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 32'h40);

        // R10 stalled memory port, write-back path exercised under back-pressure
        stall = 1'b1;
        run_vec('{20'h00010, 12'h0aa, 1'b1, 1'b1, 32'h77777007, 1'b0, 1'b0, 32'h7777701F, 2'd1}, 32'h40);
        run_vec('{20'h00011, 12'h0bb, 1'b0, 1'b1, 32'h66666000, 1'b1, 1'b0, 32'h66666000, 2'd0}, 32'h40);
        stall = 1'b0;

        // R2 top VPN with base addition wrapping modulo 2^32
        run_vec('{20'hFFFFF, 12'h123, 1'b0, 1'b0, 32'h0ABCD001, 1'b0, 1'b0, 32'h0ABCD009, 2'd1}, 32'hFFF00080);

        // R7 second access to the same warm page causes no write-back
        pt_base = 32'h40;
        poke(8'h41, 32'h1234500F);
        walk({20'h00001, 12'h004}, 1'b0, 1'b1);
        chk("R7 warm page no write", wr_cnt, 32'd0);
        chk("R3 warm page address", got_paddr, 32'h12345004);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule